// File: doc/BRIEF.md
# Four-Neuron Fixed-Point Processing Element

This block evaluates four neurons side by side on one vector of signed fixed-point activations. Every value is a 16-bit Q3.12 number (sign, three integer bits, twelve fraction bits). A fixed number of activations arrives on a 20-bit phit stream. Each neuron selected by the stored header multiplies them against its own weight memory and sums the products. The sum is saturated and mapped through one shared activation table. The element then sends a single output packet: the stored header phit, followed by one result phit for each selected neuron.

A configuration write port loads the per-neuron weights, the shared activation table and the header phit. The header's low nibble picks the neurons that run. A 2-bit field above it records how many are meant to be active. After its final input phit, a packet moves through three more stages before it is back on the output stream: saturation, table lookup and packet assembly. For one selected neuron the result appears four cycles after the final input; each further neuron adds one cycle.

Top module: `quad_neuron_pe`

## Requirements
- R1: Each selected neuron n forms the exact sum over i of weight[n][i] times activation i. It shifts that sum right by 12 bits with rounding toward minus infinity, then clamps it to the range -32768..32767 (0x8000..0x7FFF).
- R2: The payload value for neuron n is the activation table entry whose index is bits [15:10] of that neuron's saturated sum, read as a 6-bit unsigned number.
- R3: Header bit n (n = 0..3) selects neuron n. Header bits [5:4] hold the active-neuron count (00 = one up to 11 = four). The count is sent on unchanged and has no effect on which neurons produce payloads.
- R4: An output packet is the stored 20-bit header phit exactly as written, followed by one payload phit for each selected neuron in ascending index order. A payload phit has bits [19:18] = 10 (11 on the last payload), bits [17:16] = neuron index and bits [15:0] = value. A header with no neuron selected gives a header-only packet.
- R5: Let cycle 0 be the cycle in which the final input phit is presented. out_valid is high with the header in cycle 3, with payload j (0-based) in cycle 4+j, and low in every other cycle.
- R6: An input packet is N_IN consecutive phits with in_valid high. Bits [15:0] carry the activation and bits [19:16] are ignored. Phit i is multiplied by weight i.
- R7: A configuration write is taken when cfg_we is high. cfg_sel 00 writes weight [neuron = cfg_addr[3:2]][input = cfg_addr[1:0]]. cfg_sel 01 writes table entry cfg_addr[5:0]. cfg_sel 10 writes the header. Weights and table entries take cfg_wdata[15:0]; the header takes all 20 bits.
- R8: A configuration write is ignored if it arrives while an input packet is partly received or while a packet is being computed or sent.
- R9: Input phits that arrive while a packet is being computed or sent are dropped; they are not counted toward the next packet.
- R10: After reset out_valid is low, and the header, the weights and the table are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input phit present |
| in_phit | input | 20 | Input phit; activation in [15:0] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 00 weight, 01 table, 10 header |
| cfg_addr | input | 8 | Weight or table address |
| cfg_wdata | input | 20 | Write data |
| out_valid | output | 1 | Output phit present |
| out_phit | output | 20 | Header or payload phit |

## Verification
The datapath is driven with mixed-sign activations against weights of different magnitudes, so a lost sign, a wrong shift or a swapped weight index gives a different table index. Full-scale activations against the largest positive and most negative weights push the sums past both clamp limits. Several masks are used: all four neurons, the gapped mask 0101 with a mismatched count field, the upper pair only, and the empty mask. Together they separate ordering, selection, tail marking and header-only packets. Configuration writes made mid-packet and while busy, plus a stray input phit sent while busy, check that neither a later packet's weights nor its alignment are disturbed.

// File: rtl/qpe_pkg.sv
package qpe_pkg;
  localparam int DATA_W  = 16;
  localparam int PHIT_W  = 20;
  localparam int FRAC_W  = 12;
  localparam int NEURONS = 4;
  localparam int NIDX_W  = 2;

  typedef enum logic [1:0] {
    CFG_WEIGHT = 2'b00,
    CFG_TABLE  = 2'b01,
    CFG_HEADER = 2'b10,
    CFG_NONE   = 2'b11
  } cfg_sel_e;

  typedef enum logic [1:0] {
    S_COLLECT = 2'd0,
    S_CALC    = 2'd1,
    S_LOOK    = 2'd2,
    S_ENC     = 2'd3
  } pe_state_e;

  localparam logic [1:0] KIND_BODY = 2'b10;
  localparam logic [1:0] KIND_TAIL = 2'b11;

  // lowest set bit position; zero when nothing is set
  function automatic logic [NIDX_W-1:0] first_set(input logic [NEURONS-1:0] v);
    logic [NIDX_W-1:0] r;
    r = '0;
    for (int k = NEURONS - 1; k >= 0; k--) begin
      if (v[k]) r = NIDX_W'(k);
    end
    return r;
  endfunction

  function automatic logic [NEURONS-1:0] bit_of(input logic [NIDX_W-1:0] idx);
    return NEURONS'(1) << idx;
  endfunction
endpackage

// File: rtl/qpe_neuron.sv
module qpe_neuron
  import qpe_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int IN_AW = 2,
  parameter int ACC_W = 2 * DATA_W + IN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IN_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mac_en,
  input  logic              first,
  input  logic [IN_AW-1:0]  in_idx,
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] sum_sat
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(32767);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  function automatic logic [DATA_W-1:0] sat_q312(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> FRAC_W;
    if (s > SAT_HI)      return 16'h7FFF;
    else if (s < SAT_LO) return 16'h8000;
    else                 return s[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0]   wmem [N_IN];
  logic signed [ACC_W-1:0]    acc;
  logic signed [2*DATA_W-1:0] prod;
  logic signed [DATA_W-1:0]   w_sel;

  // input multiplexer: weight chosen by the position of the phit
  assign w_sel = wmem[in_idx];
  assign prod  = w_sel * $signed(x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_IN; k++) wmem[k] <= '0;
    end else if (wr_en) begin
      wmem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (mac_en) acc <= first ? ACC_W'(prod) : acc + ACC_W'(prod);
  end

  assign sum_sat = sat_q312(acc);

  a_r1_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_en |=> $stable(acc));
endmodule

// File: rtl/qpe_act_lut.sv
module qpe_act_lut
  import qpe_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] tab [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tab[k] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) tab[wr_addr] <= wr_data;
      rd_data <= tab[rd_addr];
    end
  end
endmodule

// File: rtl/quad_neuron_pe.sv
module quad_neuron_pe
  import qpe_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int LUT_AW = 6,
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PHIT_W-1:0] in_phit,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [PHIT_W-1:0] cfg_wdata,
  output logic              out_valid,
  output logic [PHIT_W-1:0] out_phit
);
  localparam int IN_AW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int ACC_W = 2 * DATA_W + IN_AW;
  localparam logic [IN_AW-1:0] LAST_IN = IN_AW'(N_IN - 1);

  pe_state_e         state;
  logic [IN_AW-1:0]  in_cnt;
  logic [PHIT_W-1:0] hdr_q;
  logic [NEURONS-1:0] hdr_mask;
  logic              idle, cfg_ok, accept, last_in;
  logic [DATA_W-1:0] sat_w [NEURONS];
  logic [DATA_W-1:0] sat_q [NEURONS];
  logic [NEURONS-1:0] pend;
  logic [NIDX_W-1:0] pick, cur_idx;
  logic              have_q, tail_q, payload_q;
  logic [LUT_AW-1:0] lut_addr;
  logic [DATA_W-1:0] lut_data;
  logic              lut_we, hdr_we;

  assign hdr_mask = hdr_q[NEURONS-1:0];
  assign idle     = (state == S_COLLECT) && (in_cnt == '0);
  assign cfg_ok   = cfg_we && idle;
  assign accept   = in_valid && (state == S_COLLECT);
  assign last_in  = accept && (in_cnt == LAST_IN);
  assign lut_we   = cfg_ok && (cfg_sel == CFG_TABLE);
  assign hdr_we   = cfg_ok && (cfg_sel == CFG_HEADER);

  // neurons in parallel, each with its own weight memory and accumulator
  for (genvar n = 0; n < NEURONS; n++) begin : g_neuron
    logic wr_n;
    assign wr_n = cfg_ok && (cfg_sel == CFG_WEIGHT) &&
                  (cfg_addr[IN_AW +: NIDX_W] == NIDX_W'(n));
    qpe_neuron #(.N_IN(N_IN), .IN_AW(IN_AW), .ACC_W(ACC_W)) u_neuron (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_n),
      .wr_addr (cfg_addr[IN_AW-1:0]),
      .wr_data (cfg_wdata[DATA_W-1:0]),
      .mac_en  (accept && hdr_mask[n]),
      .first   (in_cnt == '0),
      .in_idx  (in_cnt),
      .x       (in_phit[DATA_W-1:0]),
      .sum_sat (sat_w[n])
    );
  end

  // shared activation table, indexed by the top bits of the chosen sum
  assign pick     = first_set(pend);
  assign lut_addr = sat_q[pick][DATA_W-1 -: LUT_AW];

  qpe_act_lut #(.AW(LUT_AW)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lut_we),
    .wr_addr (cfg_addr[LUT_AW-1:0]),
    .wr_data (cfg_wdata[DATA_W-1:0]),
    .rd_addr (lut_addr),
    .rd_data (lut_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdr_q <= '0;
    else if (hdr_we) hdr_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_COLLECT;
      in_cnt    <= '0;
      pend      <= '0;
      cur_idx   <= '0;
      have_q    <= 1'b0;
      tail_q    <= 1'b0;
      payload_q <= 1'b0;
      out_valid <= 1'b0;
      out_phit  <= '0;
      for (int k = 0; k < NEURONS; k++) sat_q[k] <= '0;
    end else begin
      out_valid <= 1'b0;
      payload_q <= 1'b0;
      unique case (state)
        S_COLLECT: begin
          if (accept) begin
            in_cnt <= last_in ? '0 : in_cnt + IN_AW'(1);
            if (last_in) state <= S_CALC;
          end
        end
        S_CALC: begin
          for (int k = 0; k < NEURONS; k++) sat_q[k] <= sat_w[k];
          pend  <= hdr_mask;
          state <= S_LOOK;
        end
        S_LOOK: begin
          out_valid <= 1'b1;
          out_phit  <= hdr_q;
          cur_idx   <= pick;
          have_q    <= |pend;
          tail_q    <= (pend & ~bit_of(pick)) == '0;
          pend      <= pend & ~bit_of(pick);
          state     <= S_ENC;
        end
        S_ENC: begin
          if (have_q) begin
            out_valid <= 1'b1;
            payload_q <= 1'b1;
            out_phit  <= {(tail_q ? KIND_TAIL : KIND_BODY), cur_idx, lut_data};
            cur_idx   <= pick;
            have_q    <= |pend;
            tail_q    <= (pend & ~bit_of(pick)) == '0;
            pend      <= pend & ~bit_of(pick);
          end else begin
            state <= S_COLLECT;
          end
        end
        default: state <= S_COLLECT;
      endcase
    end
  end

  a_r4_selected_only: assert property (@(posedge clk) disable iff (!rst_n)
    payload_q |-> hdr_mask[out_phit[17:16]]);

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    payload_q && $past(payload_q) |-> out_phit[17:16] > $past(out_phit[17:16]));

  a_r4_tail_closes: assert property (@(posedge clk) disable iff (!rst_n)
    payload_q && (out_phit[19:18] == KIND_TAIL) |=> !out_valid);

  a_r5_header_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !payload_q |-> !$past(out_valid));

  a_r8_cfg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !idle |=> $stable(hdr_q));

  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_COLLECT) |=> $stable(in_cnt));
endmodule

// File: tb/quad_neuron_pe_bench.sv
module quad_neuron_pe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] in_phit = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'b11;
  logic [7:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic        out_valid;
  logic [19:0] out_phit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] m_w [4][4];
  logic [15:0] m_tab [64];
  logic [19:0] m_hdr;

  logic [19:0] q_phit [$];
  int          q_cyc  [$];
  string       q_tag  [$];

  always #10 clk = ~clk;  // 50 MHz

  quad_neuron_pe u_quad_neuron_pe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phit(in_phit),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_phit(out_phit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: every valid output phit must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_phit.size() == 0) begin
        check(1'b0, "R5 unexpected out_valid", {12'h0, out_phit}, 32'h0);
      end else begin
        logic [19:0] ep;
        int ec;
        string et;
        ep = q_phit.pop_front();
        ec = q_cyc.pop_front();
        et = q_tag.pop_front();
        check(out_phit == ep, et, {12'h0, out_phit}, {12'h0, ep});
        check(cyc == ec, "R5 output cycle", cyc, ec);
      end
    end
  end

  // restated arithmetic of R1/R2, written from the requirement
  function automatic logic [15:0] expect_val(input int n, input logic [15:0] xs [4]);
    longint s;
    logic [15:0] q;
    s = 0;
    for (int i = 0; i < 4; i++)
      s += longint'($signed(m_w[n][i])) * longint'($signed(xs[i]));
    s = s >>> 12;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    q = s[15:0];
    return m_tab[q[15:10]];
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] addr, input logic [19:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'b11;
  endtask

  task automatic set_weight(input int n, input int i, input logic [15:0] v);
    m_w[n][i] = v;
    cfg_write(2'b00, 8'(n * 4 + i), {4'h0, v});
  endtask

  task automatic set_header(input logic [19:0] h);
    m_hdr = h;
    cfg_write(2'b10, 8'h0, h);
  endtask

  // driver: pushes expected phits, then drives the input packet (R6)
  task automatic send(input logic [15:0] xs [4], input bit mid_cfg, input string tag);
    int a, j, last_n;
    @(negedge clk);
    a = cyc + 4 + 2;
    q_phit.push_back(m_hdr); q_cyc.push_back(a); q_tag.push_back({tag, " R4 header"});
    last_n = -1;
    for (int n = 0; n < 4; n++) if (m_hdr[n]) last_n = n;
    j = 0;
    for (int n = 0; n < 4; n++) begin
      if (m_hdr[n]) begin
        q_phit.push_back({(n == last_n) ? 2'b11 : 2'b10, 2'(n), expect_val(n, xs)});
        q_cyc.push_back(a + 1 + j);
        q_tag.push_back({tag, $sformatf(" R1 R2 payload n%0d", n)});
        j++;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      in_valid = 1'b1;
      in_phit = {4'hA ^ 4'(i), xs[i]};
      if (mid_cfg && i == 1) begin
        cfg_we = 1'b1; cfg_sel = 2'b10; cfg_wdata = 20'h00001;  // R8: ignored
      end else begin
        cfg_we = 1'b0; cfg_sel = 2'b11;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0; cfg_sel = 2'b11;
  endtask

  task automatic drain;
    while (q_phit.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] xa [4];
    logic [15:0] xb [4];
    logic [15:0] xf [4];
    for (int n = 0; n < 4; n++) for (int i = 0; i < 4; i++) m_w[n][i] = '0;
    for (int k = 0; k < 64; k++) m_tab[k] = '0;
    m_hdr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", {31'h0, out_valid}, 0);

    // R10: header resets to zero, so the first packet is a bare zero header
    xa = '{16'h1000, 16'h0800, 16'hF000, 16'h0400};
    send(xa, 1'b0, "R10 reset header");
    drain();

    // R7: load table and weights through the configuration port
    for (int k = 0; k < 64; k++) begin
      m_tab[k] = 16'(k * 37 + 5);
      cfg_write(2'b01, 8'(k), {4'h0, m_tab[k]});
    end
    set_weight(0, 0, 16'h1000); set_weight(0, 1, 16'h1000);
    set_weight(0, 2, 16'h1000); set_weight(0, 3, 16'h1000);
    set_weight(1, 0, 16'h0800); set_weight(1, 1, 16'hE000);
    set_weight(1, 2, 16'h3000); set_weight(1, 3, 16'hF800);
    set_weight(2, 0, 16'h7FFF); set_weight(2, 1, 16'h7FFF);
    set_weight(2, 2, 16'h7FFF); set_weight(2, 3, 16'h7FFF);
    set_weight(3, 0, 16'h8000); set_weight(3, 1, 16'h8000);
    set_weight(3, 2, 16'h8000); set_weight(3, 3, 16'h8000);

    // R1 R4: all four neurons, mixed-sign activations
    set_header(20'h4003F);
    send(xa, 1'b0, "all four mixed");
    drain();
    xb = '{16'hFE00, 16'h0300, 16'h00C0, 16'hFFF1};
    send(xb, 1'b0, "all four small");
    drain();

    // R3: gapped mask 0101 with count field 11 that disagrees
    set_header(20'h40035);
    send(xa, 1'b0, "R3 mask 0101");
    drain();

    // R4 R5: upper pair only
    set_header(20'h4001C);
    send(xb, 1'b0, "R4 mask 1100");
    drain();

    // R1: saturation in both directions
    set_header(20'h4003F);
    xf = '{16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF};
    send(xf, 1'b0, "R1 saturate high");
    drain();
    xf = '{16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF};
    send(xf, 1'b0, "R1 saturate mixed");
    drain();

    // R4: empty mask gives a header-only packet
    set_header(20'h40000);
    send(xa, 1'b0, "R4 empty mask");
    drain();

    // R8 R9: writes mid-packet and while busy are ignored; stray phit dropped
    set_header(20'h4003F);
    send(xa, 1'b1, "R8 mid-packet write");
    cfg_write(2'b00, 8'h00, 20'h00000);
    @(negedge clk);
    in_valid = 1'b1; in_phit = 20'h07777;
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    send(xb, 1'b0, "R8 R9 after busy");
    drain();

    check(q_phit.size() == 0, "R5 missing output phits", q_phit.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule